// File: doc/BRIEF.md
# Partial-Width Register File

This block stores a set of 64-bit registers that can each be reached as a whole or through four narrower views. The views are the low 32 bits, the low 16 bits, the low byte and the second byte (bits 15:8). There is one write port and a parameterised number of read ports. Every port carries a register index and a 3-bit view code. Each read port also has a sign-extension control.

The write port applies a different rule for each view. A 32-bit write clears the upper half of the register. A 16-bit or byte write merges into the old contents, so a later full-width read shows the combined value. The read ports are combinational. Each one returns the selected view extended to 64 bits with zeros or with copies of the view's top bit. When a read and a write target the same register in the same cycle, the read port sees the value the write is about to store. Indices 0 to 3 are the only ones with a second-byte view. A second-byte write to any other index raises an error flag and changes nothing.

Top module: `subreg_file`

## Requirements
- R1: After reset all 16 registers read as zero; each register holds 64 bits.
- R2: View codes are 000 full 64 bits, 001 low 32, 010 low 16, 011 bits 7:0, 100 bits 15:8. A full write with wr_en high replaces all 64 bits at the next rising clock edge.
- R3: A 32-bit write stores wr_data[31:0] in bits 31:0 and forces bits 63:32 to zero.
- R4: A 16-bit write replaces bits 15:0 with wr_data[15:0] and keeps bits 63:16.
- R5: A low-byte write replaces bits 7:0 with wr_data[7:0] and keeps all other bits.
- R6: A second-byte write to index 0 to 3 places wr_data[7:0] in bits 15:8 and keeps all other bits.
- R7: A second-byte write to index 4 or above raises wr_err in that same cycle and leaves the register unchanged. A second-byte read of such an index returns zero.
- R8: Writes with codes 101 to 111 change no register. Reads with those codes return zero.
- R9: With the read's sign-extension bit clear, the selected view appears in the low bits and all upper bits are zero.
- R10: With the sign-extension bit set, the top bit of the selected view is copied into all upper bits.
- R11: A read of the register being written in the same cycle returns the merged value that the write will store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_view | input | 3 | Write view code |
| wr_data | input | 64 | Write data, aligned at bit 0 |
| wr_err | output | 1 | Illegal second-byte write |
| rd_idx | input | 8 | Read indices, port p at bits 4p+3:4p |
| rd_view | input | 6 | Read view codes, port p at bits 3p+2:3p |
| rd_sext | input | 2 | Sign-extension control, one bit per port |
| rd_data | output | 128 | Read results, port p at bits 64p+63:64p |

## Verification
The functions that meet within one cycle are a write merge and a read of the same register, through the forwarding path. The bench provokes this with directed cycles in which a read port targets the register under a partial write. In its random phase it also steers read indices onto the write index for a large share of cycles. In each such cycle the read result is compared, before the clock edge, against the bench's own merge of the old model value with the write data. The result is then passed through the bench's view and extension function.

// File: rtl/subreg_pkg.sv
package subreg_pkg;
   typedef enum logic [2:0] {
      VW_FULL = 3'd0,
      VW_W32  = 3'd1,
      VW_W16  = 3'd2,
      VW_LO8  = 3'd3,
      VW_HI8  = 3'd4
   } view_e;
endpackage

// File: rtl/subreg_merge.sv
module subreg_merge
   import subreg_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int IW      = 4,
   parameter int HI_REGS = 4
) (
   input  logic [XLEN-1:0] old_val,
   input  logic [IW-1:0]   idx,
   input  logic [2:0]      view,
   input  logic [XLEN-1:0] din,
   output logic [XLEN-1:0] new_val,
   output logic            legal
);
   localparam logic [IW:0] HI_LIM = IW'(HI_REGS);
   logic hi_ok;
   assign hi_ok = ({1'b0, idx} < HI_LIM);

   always_comb begin
      legal   = 1'b1;
      new_val = old_val;
      case (view_e'(view))
         VW_FULL: new_val = din;
         VW_W32:  new_val = {{(XLEN-32){1'b0}}, din[31:0]};
         VW_W16:  new_val = {old_val[XLEN-1:16], din[15:0]};
         VW_LO8:  new_val = {old_val[XLEN-1:8], din[7:0]};
         VW_HI8: begin
            if (hi_ok) new_val = {old_val[XLEN-1:16], din[7:0], old_val[7:0]};
            else       legal   = 1'b0;
         end
         default: legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/subreg_view_rd.sv
module subreg_view_rd
   import subreg_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int IW      = 4,
   parameter int HI_REGS = 4
) (
   input  logic [IW-1:0]   idx,
   input  logic [2:0]      view,
   input  logic            sext,
   input  logic [XLEN-1:0] raw,
   output logic [XLEN-1:0] dout
);
   localparam logic [IW:0] HI_LIM = IW'(HI_REGS);
   logic hi_ok;
   assign hi_ok = ({1'b0, idx} < HI_LIM);

   always_comb begin
      case (view_e'(view))
         VW_FULL: dout = raw;
         VW_W32:  dout = {{(XLEN-32){sext & raw[31]}}, raw[31:0]};
         VW_W16:  dout = {{(XLEN-16){sext & raw[15]}}, raw[15:0]};
         VW_LO8:  dout = {{(XLEN-8){sext & raw[7]}}, raw[7:0]};
         VW_HI8:  dout = hi_ok ? {{(XLEN-8){sext & raw[15]}}, raw[15:8]} : '0;
         default: dout = '0;
      endcase
   end

   always_comb begin
      // R9
      if (!sext && view == 3'd3)
         zext_rd_chk: assert (dout[XLEN-1:8] == '0);
      // R8
      if (view > 3'd4)
         badcode_rd_chk: assert (dout == '0);
   end
endmodule

// File: rtl/subreg_file.sv
module subreg_file
   import subreg_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int NUM_REGS = 16,
   parameter int HI_REGS  = 4,
   parameter int NUM_RD   = 2,
   localparam int IW      = $clog2(NUM_REGS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [IW-1:0]          wr_idx,
   input  logic [2:0]             wr_view,
   input  logic [XLEN-1:0]        wr_data,
   output logic                   wr_err,
   input  logic [NUM_RD*IW-1:0]   rd_idx,
   input  logic [NUM_RD*3-1:0]    rd_view,
   input  logic [NUM_RD-1:0]      rd_sext,
   output logic [NUM_RD*XLEN-1:0] rd_data
);
   if (XLEN <= 32 || XLEN % 8 != 0) begin : g_bad_xlen
      $error("XLEN must exceed 32 and be a multiple of 8");
   end
   if (HI_REGS > NUM_REGS || NUM_RD < 1 || (1 << IW) != NUM_REGS) begin : g_bad_cfg
      $error("bad register count, second-byte range or read port count");
   end

   logic [XLEN-1:0] regs [NUM_REGS];
   logic [XLEN-1:0] wr_merged;
   logic            wr_legal;

   subreg_merge #(.XLEN(XLEN), .IW(IW), .HI_REGS(HI_REGS)) merge_i (
      .old_val (regs[wr_idx]),
      .idx     (wr_idx),
      .view    (wr_view),
      .din     (wr_data),
      .new_val (wr_merged),
      .legal   (wr_legal)
   );

   assign wr_err = wr_en && (wr_view == 3'd4) && !wr_legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else if (wr_en && wr_legal) begin
         regs[wr_idx] <= wr_merged;
      end
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      logic [IW-1:0]   ridx;
      logic [XLEN-1:0] raw;
      assign ridx = rd_idx[p*IW +: IW];
      assign raw  = (wr_en && wr_legal && wr_idx == ridx) ? wr_merged : regs[ridx];
      subreg_view_rd #(.XLEN(XLEN), .IW(IW), .HI_REGS(HI_REGS)) view_i (
         .idx  (ridx),
         .view (rd_view[p*3 +: 3]),
         .sext (rd_sext[p]),
         .raw  (raw),
         .dout (rd_data[p*XLEN +: XLEN])
      );
   end

   // R3
   zext32_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_view == 3'd1) |=> (regs[$past(wr_idx)][XLEN-1:32] == '0));
   // R4
   merge16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_view == 3'd2) |=>
      (regs[$past(wr_idx)][XLEN-1:16] == $past(regs[wr_idx][XLEN-1:16])));
   // R5
   merge_lo8_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_view == 3'd3) |=>
      (regs[$past(wr_idx)][XLEN-1:8] == $past(regs[wr_idx][XLEN-1:8])));
   // R6
   merge_hi8_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_view == 3'd4 && !wr_err) |=>
      (regs[$past(wr_idx)][XLEN-1:16] == $past(regs[wr_idx][XLEN-1:16]) &&
       regs[$past(wr_idx)][7:0] == $past(regs[wr_idx][7:0])));
   // R7
   hi8_err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |=> (regs[$past(wr_idx)] == $past(regs[wr_idx])));
   // R8
   badcode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_view > 3'd4) |=> (regs[$past(wr_idx)] == $past(regs[wr_idx])));
endmodule

// File: tb/subreg_file_tb_top.sv
module subreg_file_tb_top;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         wr_en;
   logic [3:0]   wr_idx;
   logic [2:0]   wr_view;
   logic [63:0]  wr_data;
   logic         wr_err;
   logic [7:0]   rd_idx;
   logic [5:0]   rd_view;
   logic [1:0]   rd_sext;
   logic [127:0] rd_data;

   logic [63:0] mdl [16];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   subreg_file dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_view(wr_view), .wr_data(wr_data), .wr_err(wr_err),
      .rd_idx(rd_idx), .rd_view(rd_view), .rd_sext(rd_sext), .rd_data(rd_data)
   );

   function automatic logic [63:0] f_merge(logic [63:0] old, logic [2:0] v,
                                           logic [63:0] d, logic [3:0] idx);
      case (v)
         3'd0: return d;
         3'd1: return {32'h0, d[31:0]};
         3'd2: return {old[63:16], d[15:0]};
         3'd3: return {old[63:8], d[7:0]};
         3'd4: return (idx < 4) ? {old[63:16], d[7:0], old[7:0]} : old;
         default: return old;
      endcase
   endfunction

   function automatic logic [63:0] f_view(logic [63:0] raw, logic [2:0] v,
                                          logic sx, logic [3:0] idx);
      logic [63:0] r;
      int w;
      r = 64'h0;
      w = 64;
      case (v)
         3'd0: begin r = raw; w = 64; end
         3'd1: begin r[31:0] = raw[31:0]; w = 32; end
         3'd2: begin r[15:0] = raw[15:0]; w = 16; end
         3'd3: begin r[7:0] = raw[7:0]; w = 8; end
         3'd4: begin if (idx < 4) r[7:0] = raw[15:8]; w = 8; end
         default: return 64'h0;
      endcase
      if (sx && w < 64 && r[w-1])
         for (int b = w; b < 64; b++) r[b] = 1'b1;
      return r;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(string req, logic we, logic [3:0] widx, logic [2:0] wv,
                      logic [63:0] wd, logic [3:0] r0, logic [2:0] v0, logic s0,
                      logic [3:0] r1, logic [2:0] v1, logic s1);
      logic [63:0] nv, raw0, raw1;
      @(negedge clk);
      wr_en = we; wr_idx = widx; wr_view = wv; wr_data = wd;
      rd_idx = {r1, r0}; rd_view = {v1, v0}; rd_sext = {s1, s0};
      #1;
      nv   = f_merge(mdl[widx], wv, wd, widx);
      raw0 = (we && widx == r0) ? nv : mdl[r0];
      raw1 = (we && widx == r1) ? nv : mdl[r1];
      check({req, " rd0"}, rd_data[63:0],   f_view(raw0, v0, s0, r0));
      check({req, " rd1"}, rd_data[127:64], f_view(raw1, v1, s1, r1));
      check({req, " err"}, {63'h0, wr_err}, {63'h0, we && wv == 3'd4 && widx >= 4});
      @(posedge clk);
      if (we) mdl[widx] = nv;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [3:0] wi;
      for (int i = 0; i < 16; i++) mdl[i] = 64'h0;
      rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_view = '0; wr_data = '0;
      rd_idx = '0; rd_view = '0; rd_sext = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state of every register
      for (int i = 0; i < 16; i += 2)
         cyc("R1", 0, 0, 0, 0, 4'(i), 0, 0, 4'(i + 1), 0, 0);

      // R2 full write
      cyc("R2", 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0, 0);
      cyc("R2", 0, 0, 0, 0, 1, 0, 0, 1, 0, 0);
      check("R2 literal", rd_data[63:0], 64'hFFFF_FFFF_FFFF_FFFF);
      // R3 32-bit write clears upper half
      cyc("R3", 1, 1, 1, 64'hA5A5_A5A5_1234_5678, 0, 0, 0, 0, 0, 0);
      cyc("R3", 0, 0, 0, 0, 1, 0, 0, 1, 1, 0);
      check("R3 literal", rd_data[63:0], 64'h0000_0000_1234_5678);
      // R4 16-bit merge
      cyc("R4", 1, 2, 0, 64'h1122_3344_5566_7788, 0, 0, 0, 0, 0, 0);
      cyc("R4", 1, 2, 2, 64'hFFFF_FFFF_FFFF_BEEF, 0, 0, 0, 0, 0, 0);
      cyc("R4", 0, 0, 0, 0, 2, 0, 0, 2, 2, 0);
      check("R4 literal", rd_data[63:0], 64'h1122_3344_5566_BEEF);
      // R5 low byte merge
      cyc("R5", 1, 2, 3, 64'hFFFF_FFFF_FFFF_FF99, 0, 0, 0, 0, 0, 0);
      cyc("R5", 0, 0, 0, 0, 2, 0, 0, 2, 3, 0);
      check("R5 literal", rd_data[63:0], 64'h1122_3344_5566_BE99);
      // R6 second byte merge, index 2
      cyc("R6", 1, 2, 4, 64'hFFFF_FFFF_FFFF_FFC2, 0, 0, 0, 0, 0, 0);
      cyc("R6", 0, 0, 0, 0, 2, 0, 0, 2, 4, 0);
      check("R6 literal", rd_data[63:0], 64'h1122_3344_5566_C299);
      // R7 second byte on index 9
      cyc("R7", 1, 9, 0, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0, 0, 0);
      cyc("R7", 1, 9, 4, 64'h0000_0000_0000_0055, 9, 0, 0, 9, 4, 1);
      check("R7 err", {63'h0, wr_err}, 64'h1);
      cyc("R7", 0, 0, 0, 0, 9, 0, 0, 9, 4, 0);
      check("R7 literal", rd_data[63:0], 64'h0123_4567_89AB_CDEF);
      // R8 reserved codes
      cyc("R8", 1, 2, 5, 64'h0, 2, 6, 0, 2, 7, 1);
      check("R8 read zero", rd_data[63:0], 64'h0);
      cyc("R8", 1, 2, 7, 64'h0, 2, 0, 0, 2, 5, 0);
      check("R8 kept", rd_data[63:0], 64'h1122_3344_5566_C299);
      // R9 / R10 extension
      cyc("R9", 1, 3, 0, 64'h0000_0000_8000_8080, 0, 0, 0, 0, 0, 0);
      cyc("R9", 0, 0, 0, 0, 3, 3, 0, 3, 2, 0);
      check("R9 literal", rd_data[63:0], 64'h80);
      cyc("R10", 0, 0, 0, 0, 3, 3, 1, 3, 1, 1);
      check("R10 literal", rd_data[63:0], 64'hFFFF_FFFF_FFFF_FF80);
      cyc("R10", 0, 0, 0, 0, 3, 4, 1, 2, 4, 1);
      check("R10 hi8", rd_data[63:0], 64'hFFFF_FFFF_FFFF_FF80);
      // R11 same-cycle forwarding
      cyc("R11", 1, 4, 0, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 0, 0, 0, 0);
      cyc("R11", 1, 4, 2, 64'h0000_0000_0000_1234, 4, 0, 0, 4, 2, 1);
      check("R11 literal", rd_data[63:0], 64'hDEAD_BEEF_CAFE_1234);
      cyc("R11", 1, 0, 4, 64'h0000_0000_0000_00F1, 0, 4, 1, 0, 0, 0);
      check("R11 hi8 fwd", rd_data[63:0], 64'hFFFF_FFFF_FFFF_FFF1);

      // constrained random, fixed seed
      void'($urandom(32'd2024));
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] a, b;
         wi = 4'($urandom_range(0, 15));
         a  = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : wi;
         b  = ($urandom_range(0, 1) == 0) ? 4'($urandom_range(0, 15)) : wi;
         cyc("RND", 1'($urandom_range(0, 1)), wi,
             ($urandom_range(0, 7) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4)),
             {$urandom, $urandom},
             a, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
             b, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule